// File: doc/BRIEF.md
# Read Capture Delay Trainer (MPR Pattern Sweep)

This block calibrates the read capture delay of every byte lane of a DDR3 interface. On start it asks the command path for a mode-register write to MR3 that sets the A2 bit. With that bit set, every read returns the memory's fixed multi-purpose register pattern instead of array data. Training therefore needs no extra calibration pins and no earlier writes to memory.

The trainer then walks a shared delay code from 0 up to its maximum. At each code it issues a programmable number of reads and waits for each lane's captured burst. It compares every burst with the known pattern. Each lane has its own window tracker, which keeps the longest contiguous run of passing codes. When the sweep ends, each lane gets the midpoint of its best run, or zero and an error flag if no code passed. A final MR3 write clears A2 so that normal array reads resume, and then done is raised. The delay outputs drive the PHY's delay cells directly, both during the sweep and afterwards.

Top module: `rdlvl_trainer`

## Requirements
- R1: Starting the trainer (start_i high while idle or done) first issues a mode-register write with cmd_op_o = 2'b01, cmd_ba_o = 3 and cmd_addr_o bit 2 = 1, bits 1:0 = 0. No other command comes before it.
- R2: The expected burst for a lane has beat k (k = 0..7) occupying bits [k*DQ_W +: DQ_W] of that lane's rd_data_i slice. Every bit of beat k equals k mod 2, so the pattern is 0,1,0,1,... A burst matches only if all of its bits are equal to this pattern.
- R3: For each delay code, exactly max(N,1) reads (cmd_op_o = 2'b10) are issued, where N is rd_cnt_i sampled at start. A new read is issued only after every lane has returned rd_valid_i for the previous one. A code passes for a lane only if all of its bursts match.
- R4: During the sweep, dly_o carries the same code on all lanes. The codes run in ascending order from 0 to 2^DLY_W-1, and each read carries the code being tested.
- R5: After the sweep, each lane's dly_o equals floor((first+last)/2) of its longest contiguous run of passing codes. When two runs are equally long, the earlier run wins.
- R6: A lane with no passing code has err_o high and dly_o equal to 0 once done_o is high.
- R7: After the last code, a mode-register write to bank 3 with cmd_addr_o = 0 is issued. No read follows it, and done_o rises in the cycle after it is accepted.
- R8: A command with cmd_valid_o high holds cmd_op_o, cmd_ba_o and cmd_addr_o stable until cmd_ready_i. Once high, done_o and the trained delays hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin training when idle or done |
| rd_cnt_i | input | RCNT_W | Reads per delay code (0 behaves as 1), sampled at start |
| done_o | output | 1 | Training complete, held until next start |
| cmd_valid_o | output | 1 | Command request valid |
| cmd_ready_i | input | 1 | Command accepted this cycle |
| cmd_op_o | output | 2 | 01 = mode-register write, 10 = read |
| cmd_ba_o | output | 3 | Bank / mode-register select |
| cmd_addr_o | output | ADDR_W | Mode-register value |
| rd_valid_i | input | LANES | Per-lane captured burst valid |
| rd_data_i | input | LANES*DQ_W*8 | Per-lane captured burst, lane l at [l*DQ_W*8 +: DQ_W*8] |
| dly_o | output | LANES*DLY_W | Per-lane read capture delay code |
| err_o | output | LANES | Lane found no passing code |

## Verification
The bench feeds random per-lane pass bitmaps with scattered noise, and separately flags codes where only the last of the N bursts is corrupted. A design that judged a code on its first burst alone would then report a window that is too wide. Directed runs cover these cases:
- two equally long runs: a tracker that keeps the later one picks the wrong centre;
- a single passing code at the top of the range: an off-by-one in the end test drops the last code;
- a lane with no passing code: without the error path a stale or nonzero delay remains;
- N = 0: a naive counter would wrap and issue many reads.

Response latency varies per lane, so a sequencer that issues the next read before every lane has answered shows up as an overlapping request.

// File: rtl/rdlvl_pkg.sv
package rdlvl_pkg;
  localparam int BURST_LEN  = 8;
  localparam int MPR_EN_BIT = 2;
  localparam logic [2:0] MR3_BA = 3'd3;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_MRW  = 2'b01,
    OP_READ = 2'b10
  } cmd_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MR_ON,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_EVAL,
    ST_MR_OFF,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/rdlvl_burst_cmp.sv
module rdlvl_burst_cmp
  import rdlvl_pkg::*;
#(
  parameter int DQ_W = 8
) (
  input  logic [DQ_W*BURST_LEN-1:0] burst_i,
  output logic                      match_o
);
  logic [DQ_W*BURST_LEN-1:0] expect_w;

  // alternating MPR pattern: odd beats all ones, even beats all zeros
  for (genvar k = 0; k < BURST_LEN; k++) begin : g_beat
    assign expect_w[k*DQ_W +: DQ_W] = (k % 2 == 1) ? {DQ_W{1'b1}} : {DQ_W{1'b0}};
  end

  assign match_o = (burst_i == expect_w);
endmodule

// File: rtl/rdlvl_window.sv
module rdlvl_window #(
  parameter int DLY_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             pass_i,
  input  logic [DLY_W-1:0] code_i,
  output logic             found_o,
  output logic [DLY_W-1:0] center_o
);
  localparam int LEN_W = DLY_W + 1;
  localparam int SUM_W = DLY_W + 2;

  logic [DLY_W-1:0] run_start_q, best_start_q, nxt_start;
  logic [LEN_W-1:0] run_len_q, best_len_q, nxt_len;
  logic [SUM_W-1:0] sum_w;

  always_comb begin
    nxt_len   = run_len_q + LEN_W'(1);
    nxt_start = (run_len_q == '0) ? code_i : run_start_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_start_q  <= '0;
      run_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (clr_i) begin
      run_start_q  <= '0;
      run_len_q    <= '0;
      best_start_q <= '0;
      best_len_q   <= '0;
    end else if (upd_i) begin
      if (pass_i) begin
        run_len_q   <= nxt_len;
        run_start_q <= nxt_start;
        // strict compare keeps the earliest of equal runs
        if (nxt_len > best_len_q) begin
          best_len_q   <= nxt_len;
          best_start_q <= nxt_start;
        end
      end else begin
        run_len_q <= '0;
      end
    end
  end

  // first + last = 2*start + len - 1
  assign sum_w    = ({2'b00, best_start_q} << 1) + {1'b0, best_len_q} - SUM_W'(1);
  assign found_o  = (best_len_q != '0);
  assign center_o = sum_w[DLY_W:1];

  // R5
  best_len_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> best_len_q >= $past(best_len_q));

  // R5
  run_le_best_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_len_q <= best_len_q);
endmodule

// File: rtl/rdlvl_seq.sv
module rdlvl_seq
  import rdlvl_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DLY_W  = 5,
  parameter int RCNT_W = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [RCNT_W-1:0] rd_cnt_i,
  input  logic              cmd_ready_i,
  input  logic [LANES-1:0]  lane_valid_i,
  input  logic [LANES-1:0]  lane_match_i,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_op_o,
  output logic [2:0]        cmd_ba_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [DLY_W-1:0]  code_o,
  output logic              sweep_o,
  output logic              clr_o,
  output logic              upd_o,
  output logic [LANES-1:0]  pass_o,
  output logic              done_o
);
  localparam logic [DLY_W-1:0] CODE_MAX = '1;

  seq_st_e           st_q;
  logic [DLY_W-1:0]  code_q;
  logic [RCNT_W-1:0] rcnt_q, n_q;
  logic [LANES-1:0]  got_q, pass_q, got_nxt;
  logic [RCNT_W:0]   rcnt_inc;
  logic              last_rd, accept;

  assign accept   = ((st_q == ST_IDLE) || (st_q == ST_DONE)) && start_i;
  assign got_nxt  = got_q | lane_valid_i;
  assign rcnt_inc = {1'b0, rcnt_q} + (RCNT_W+1)'(1);
  assign last_rd  = (rcnt_inc >= {1'b0, n_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      code_q <= '0;
      rcnt_q <= '0;
      n_q    <= '0;
      got_q  <= '0;
      pass_q <= '0;
      done_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: if (start_i) begin
          st_q   <= ST_MR_ON;
          n_q    <= rd_cnt_i;
          done_o <= 1'b0;
        end
        ST_MR_ON: if (cmd_ready_i) begin
          st_q   <= ST_RD_REQ;
          code_q <= '0;
          rcnt_q <= '0;
          pass_q <= '1;
        end
        ST_RD_REQ: if (cmd_ready_i) begin
          st_q  <= ST_RD_WAIT;
          got_q <= '0;
        end
        ST_RD_WAIT: begin
          got_q  <= got_nxt;
          pass_q <= pass_q & ~(lane_valid_i & ~got_q & ~lane_match_i);
          if (&got_nxt) begin
            if (last_rd) st_q <= ST_EVAL;
            else begin
              rcnt_q <= rcnt_inc[RCNT_W-1:0];
              st_q   <= ST_RD_REQ;
            end
          end
        end
        ST_EVAL: begin
          if (code_q == CODE_MAX) st_q <= ST_MR_OFF;
          else begin
            code_q <= code_q + DLY_W'(1);
            rcnt_q <= '0;
            pass_q <= '1;
            st_q   <= ST_RD_REQ;
          end
        end
        ST_MR_OFF: if (cmd_ready_i) begin
          st_q   <= ST_DONE;
          done_o <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid_o = 1'b0;
    cmd_op_o    = OP_NONE;
    cmd_ba_o    = '0;
    cmd_addr_o  = '0;
    unique case (st_q)
      ST_MR_ON: begin
        cmd_valid_o            = 1'b1;
        cmd_op_o               = OP_MRW;
        cmd_ba_o               = MR3_BA;
        cmd_addr_o[MPR_EN_BIT] = 1'b1;
      end
      ST_MR_OFF: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_MRW;
        cmd_ba_o    = MR3_BA;
      end
      ST_RD_REQ: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_READ;
      end
      default: ;
    endcase
  end

  assign code_o  = code_q;
  assign sweep_o = (st_q == ST_RD_REQ) || (st_q == ST_RD_WAIT) || (st_q == ST_EVAL);
  assign clr_o   = accept;
  assign upd_o   = (st_q == ST_EVAL);
  assign pass_o  = pass_q;

  // R8
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_ba_o) && $stable(cmd_addr_o));

  // R1
  mrw_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_op_o == OP_MRW |-> cmd_ba_o == MR3_BA && cmd_addr_o[1:0] == 2'b00);

  // R7
  done_after_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cmd_valid_o && cmd_ready_i && cmd_op_o == OP_MRW && !cmd_addr_o[MPR_EN_BIT]));

  // R4
  code_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(code_q) |-> (code_q == $past(code_q) + DLY_W'(1)) || (code_q == '0));

  // R3
  rd_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_o |-> ({1'b0, rcnt_q} < {1'b0, n_q}) || (rcnt_q == '0));
endmodule

// File: rtl/rdlvl_trainer.sv
module rdlvl_trainer
  import rdlvl_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DQ_W   = 8,
  parameter int DLY_W  = 5,
  parameter int RCNT_W = 4,
  parameter int ADDR_W = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [RCNT_W-1:0]               rd_cnt_i,
  output logic                            done_o,
  output logic                            cmd_valid_o,
  input  logic                            cmd_ready_i,
  output logic [1:0]                      cmd_op_o,
  output logic [2:0]                      cmd_ba_o,
  output logic [ADDR_W-1:0]               cmd_addr_o,
  input  logic [LANES-1:0]                rd_valid_i,
  input  logic [LANES*DQ_W*BURST_LEN-1:0] rd_data_i,
  output logic [LANES*DLY_W-1:0]          dly_o,
  output logic [LANES-1:0]                err_o
);
  localparam int BW = DQ_W * BURST_LEN;

  logic [LANES-1:0] match_w, pass_w, found_w;
  logic [DLY_W-1:0] code_w;
  logic             sweep_w, clr_w, upd_w;

  rdlvl_seq #(
    .LANES(LANES), .DLY_W(DLY_W), .RCNT_W(RCNT_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .rd_cnt_i     (rd_cnt_i),
    .cmd_ready_i  (cmd_ready_i),
    .lane_valid_i (rd_valid_i),
    .lane_match_i (match_w),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_op_o     (cmd_op_o),
    .cmd_ba_o     (cmd_ba_o),
    .cmd_addr_o   (cmd_addr_o),
    .code_o       (code_w),
    .sweep_o      (sweep_w),
    .clr_o        (clr_w),
    .upd_o        (upd_w),
    .pass_o       (pass_w),
    .done_o       (done_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DLY_W-1:0] center_w;

    rdlvl_burst_cmp #(.DQ_W(DQ_W)) u_cmp (
      .burst_i (rd_data_i[l*BW +: BW]),
      .match_o (match_w[l])
    );

    rdlvl_window #(.DLY_W(DLY_W)) u_win (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_w),
      .upd_i    (upd_w),
      .pass_i   (pass_w[l]),
      .code_i   (code_w),
      .found_o  (found_w[l]),
      .center_o (center_w)
    );

    assign dly_o[l*DLY_W +: DLY_W] = sweep_w ? code_w : (found_w[l] ? center_w : '0);
    assign err_o[l] = done_o && !found_w[l];
  end
endmodule

// File: tb/sim_rdlvl_trainer.sv
module sim_rdlvl_trainer;
  localparam int LANES = 2, DQ_W = 8, DLY_W = 5, RCNT_W = 4, ADDR_W = 16;
  localparam int BW = DQ_W * 8, NCODE = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, cmd_ready_i = 1'b0;
  logic [RCNT_W-1:0] rd_cnt_i = '0;
  logic done_o, cmd_valid_o;
  logic [1:0] cmd_op_o;
  logic [2:0] cmd_ba_o;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic [LANES-1:0] rd_valid_i = '0;
  logic [LANES*BW-1:0] rd_data_i = '0;
  logic [LANES*DLY_W-1:0] dly_o;
  logic [LANES-1:0] err_o;

  always #10 clk_i = ~clk_i;

  rdlvl_trainer #(.LANES(LANES), .DQ_W(DQ_W), .DLY_W(DLY_W), .RCNT_W(RCNT_W), .ADDR_W(ADDR_W)) u0 (
    .clk_i, .rst_ni, .start_i, .rd_cnt_i, .done_o, .cmd_valid_o, .cmd_ready_i,
    .cmd_op_o, .cmd_ba_o, .cmd_addr_o, .rd_valid_i, .rd_data_i, .dly_o, .err_o);

  int checks = 0, fails = 0;
  int pend [LANES];
  logic [BW-1:0] resp [LANES];
  bit [31:0] pmask [LANES], flaky [LANES];
  int n_eff, cur_code, rd_in_code, n_mrw, n_cmd, early_bad, order_bad, skew_bad, after_off;
  int reads_per [NCODE];
  logic [ADDR_W-1:0] first_addr, last_mrw_addr;
  logic [2:0] first_ba;
  logic [1:0] first_op;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] pat();
    logic [BW-1:0] p;
    for (int k = 0; k < 8; k++) p[k*DQ_W +: DQ_W] = (k % 2 == 1) ? '1 : '0;
    return p;
  endfunction

  function automatic int exp_mid(bit [31:0] m);
    int bs = 0, bl = 0, cs = 0, cl = 0;
    for (int c = 0; c < NCODE; c++) begin
      if (m[c]) begin
        if (cl == 0) cs = c;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    return (bl == 0) ? -1 : (2 * bs + bl - 1) / 2;
  endfunction

  task automatic tick();
    logic [BW-1:0] one;
    int code;
    bit ok;
    @(negedge clk_i);
    for (int l = 0; l < LANES; l++) begin
      rd_valid_i[l] = 1'b0;
      if (pend[l] == 1) begin
        rd_valid_i[l] = 1'b1;
        rd_data_i[l*BW +: BW] = resp[l];
        pend[l] = 0;
      end else if (pend[l] > 1) pend[l]--;
    end
    cmd_ready_i = ($urandom % 4) != 0;
    if (cmd_valid_o && cmd_ready_i) begin
      if (n_cmd == 0) begin first_op = cmd_op_o; first_ba = cmd_ba_o; first_addr = cmd_addr_o; end
      n_cmd++;
      if (cmd_op_o == 2'b01) begin n_mrw++; last_mrw_addr = cmd_addr_o; end
      else if (cmd_op_o == 2'b10) begin
        code = int'(dly_o[DLY_W-1:0]);
        if (dly_o[DLY_W +: DLY_W] != dly_o[DLY_W-1:0]) skew_bad++;
        if (code < cur_code) order_bad++;
        if (n_mrw >= 2) after_off++;
        if (code != cur_code) begin cur_code = code; rd_in_code = 0; end
        reads_per[code]++;
        for (int l = 0; l < LANES; l++) begin
          if (pend[l] != 0) early_bad++;
          ok = pmask[l][code] && !(flaky[l][code] && rd_in_code == n_eff - 1);
          one = '0;
          one[$urandom % BW] = 1'b1;
          resp[l] = ok ? pat() : (pat() ^ one);
          pend[l] = 1 + ($urandom % 4);
        end
        rd_in_code++;
      end
    end
  endtask

  task automatic run(input int n, input bit [31:0] m0, input bit [31:0] f0,
                     input bit [31:0] m1, input bit [31:0] f1);
    int bad, em, lim;
    logic [LANES*DLY_W-1:0] held;
    pmask[0] = m0; flaky[0] = f0; pmask[1] = m1; flaky[1] = f1;
    n_eff = (n == 0) ? 1 : n;
    cur_code = -1; rd_in_code = 0; n_mrw = 0; n_cmd = 0;
    early_bad = 0; order_bad = 0; skew_bad = 0; after_off = 0;
    for (int c = 0; c < NCODE; c++) reads_per[c] = 0;
    for (int l = 0; l < LANES; l++) pend[l] = 0;
    @(negedge clk_i);
    rd_cnt_i = RCNT_W'(n);
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    lim = 0;
    while (!done_o && lim < 30000) begin tick(); lim++; end
    // R1 first command turns MPR on
    chk(first_op == 2'b01 && first_ba == 3'd3 && first_addr[2] && first_addr[1:0] == 2'b00,
        "R1 first cmd MR3 A2 set", int'(first_addr), 4);
    // R3 reads per code
    bad = 0;
    for (int c = 0; c < NCODE; c++) if (reads_per[c] != n_eff) bad++;
    chk(bad == 0, "R3 reads per code", bad, 0);
    chk(early_bad == 0, "R3 read before all lanes returned", early_bad, 0);
    // R4 ascending shared code
    chk(order_bad == 0 && skew_bad == 0, "R4 sweep order/lane skew", order_bad + skew_bad, 0);
    // R7 final MRW clears A2, no reads after
    chk(n_mrw == 2 && last_mrw_addr == '0 && after_off == 0, "R7 MPR off before done",
        int'(last_mrw_addr) + after_off, 0);
    for (int l = 0; l < LANES; l++) begin
      em = exp_mid(pmask[l] & ~flaky[l]);
      if (em < 0) begin
        // R6
        chk(err_o[l] == 1'b1 && dly_o[l*DLY_W +: DLY_W] == '0, "R6 no-pass lane err/zero",
            int'(dly_o[l*DLY_W +: DLY_W]) + 100 * int'(!err_o[l]), 0);
      end else begin
        // R5 (R2 pattern judged per burst)
        chk(err_o[l] == 1'b0 && int'(dly_o[l*DLY_W +: DLY_W]) == em, "R5 lane centre",
            int'(dly_o[l*DLY_W +: DLY_W]), em);
      end
    end
    held = dly_o;
    repeat (3) tick();
    // R8 done and delays hold
    chk(done_o == 1'b1 && dly_o == held, "R8 done/delay hold", int'(done_o), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    bit [31:0] m [LANES];
    int lo, len;
    void'($urandom(32'h5eed_0042));
    for (int l = 0; l < LANES; l++) pend[l] = 0;
    repeat (3) @(negedge clk_i);
    chk(!done_o && !cmd_valid_o && dly_o == '0 && err_o == '0, "reset state", int'(dly_o), 0);
    rst_ni = 1'b1;
    // directed
    run(4, 32'h001F_FC00, 32'h0, 32'h0000_0018, 32'h0);   // 10..20 -> 15, 3..4 -> 3
    run(2, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0);           // R6 lane0, full range -> 15
    run(3, 32'h0000_1E3C, 32'h0, 32'h8000_0000, 32'h0);   // tie 2..5 vs 9..12 -> 3, top code 31
    run(3, 32'h0000_0001, 32'h0, 32'h0000_01FF, 32'h0000_0010); // flaky code 4 -> tie, 1
    run(0, 32'h00F0_0000, 32'h0, 32'h0, 32'h0);           // N=0 behaves as 1
    // constrained random
    for (int i = 0; i < 6; i++) begin
      for (int l = 0; l < LANES; l++) begin
        lo = $urandom % 32;
        len = $urandom % 14;
        m[l] = '0;
        for (int c = lo; c < lo + len && c < 32; c++) m[l][c] = 1'b1;
        m[l] = m[l] | ($urandom & $urandom & $urandom);
        if ($urandom % 7 == 0) m[l] = '0;
      end
      run($urandom % 5, m[0], $urandom & $urandom & $urandom & $urandom,
          m[1], $urandom & $urandom & $urandom & $urandom);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule